// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It drives six analog switch controls: signal select, zero-input select, auto-zero, input-to-integrator, reference-to-integrator and integrator reset. It times the conversion and delivers a BCD result. A start pulse first opens a settle interval in which the front end is switched to the signal and the integrator is released. On the clock edge that follows, the integrator charges from the input for a fixed count of clock cycles. It then discharges from the reference until an external comparator reports that the integrator has returned to zero.

One count chain serves both slopes. It has DIGITS decades of BCD followed by a 2-bit leading stage. The chain counts the charge phase, is cleared at the end of that phase, and then counts the discharge phase. The discharge count is transferred to output latches together with an overrange flag. A gate output marks the charge phase. A one-cycle done strobe marks each transfer. If the comparator never trips, a timeout ends the discharge.

Top module: `dslope_seq`

## Requirements
- R1: After reset and between conversions, the block is idle. In idle, sw_zero_in, sw_autozero and sw_int_reset are 1 and the other switch outputs and gate are 0. Right after reset, result = 0, overrange = 0 and done = 0.
- R2: When start is sampled high in idle at edge k, the settle outputs are present from edge k up to edge k+SETTLE_CYCLES. At that edge the charge phase begins.
- R3: During settle, sw_signal is 1. sw_zero_in, sw_autozero, sw_int_reset, sw_int_input, sw_int_ref and gate are all 0.
- R4: During the charge phase, sw_signal, sw_int_input and gate are 1 and the other switches are 0. The phase lasts exactly 2*10^DIGITS clock cycles.
- R5: The discharge phase follows immediately. During it, sw_int_ref, sw_zero_in and sw_autozero are 1 and sw_signal, sw_int_input, sw_int_reset and gate are 0.
- R6: The comparator may first be sampled high at the (N+1)-th edge after discharge begins. At that edge, result takes N in BCD, done is high for exactly one cycle and the block returns to idle. Result layout: decade i occupies bits [4i+3:4i], least significant first, and the 2-bit leading stage occupies bits [4*DIGITS+1:4*DIGITS].
- R7: overrange is 1 exactly when the transferred count is 2*10^DIGITS or more.
- R8: If the comparator is still low when the discharge count reaches 4*10^DIGITS-1, the block ends the discharge at the 4*10^DIGITS-th edge. The result is 4*10^DIGITS-1, overrange is 1, done pulses and the block returns to idle. A comparator that trips on that same edge takes priority and is treated as a normal end of conversion.
- R9: result and overrange change only on the edge that raises done, and they hold their values until the next transfer.
- R10: A start pulse outside idle has no effect.
- R11: The comparator has no effect outside the discharge phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, sampled in idle |
| cmp_zero | input | 1 | Comparator: integrator has returned to zero |
| sw_signal | output | 1 | Connect the signal to the front end |
| sw_zero_in | output | 1 | Connect the zero input to the front end |
| sw_autozero | output | 1 | Enable the auto-zero loop |
| sw_int_input | output | 1 | Connect the front end to the integrator |
| sw_int_ref | output | 1 | Connect the reference to the integrator |
| sw_int_reset | output | 1 | Hold the integrator at zero |
| gate | output | 1 | High during the charge phase |
| result | output | 4*DIGITS+2 | Latched BCD count |
| overrange | output | 1 | Latched overrange flag |
| done | output | 1 | One-cycle transfer strobe |

## Verification
The phase register drives every switch output directly. A wrong phase therefore shows at the switch pins on the very next clock, as a forbidden pattern or as a settle or gate width that is off by whole cycles. A fault in the count chain or in its clear shows only at the next done strobe, as a result that differs from the discharge length. The bench models the comparator with a chosen discharge length and compares the latched value, flag and strobe timing against expected values. These cover both sides of the overrange boundary, the timeout edge, and a comparator or start pulse arriving outside its phase.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETTLE  = 2'd1,
        PH_RUNUP   = 2'd2,
        PH_RUNDOWN = 2'd3
    } phase_e;

    function automatic int unsigned pow10(input int unsigned e);
        int unsigned v;
        v = 1;
        for (int unsigned i = 0; i < e; i++) v = v * 10;
        return v;
    endfunction

endpackage

// File: rtl/dslope_bcd_chain.sv
module dslope_bcd_chain
    import dslope_pkg::*;
#(
    parameter int unsigned DIGITS = 4,
    localparam int unsigned W = 4 * DIGITS + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    typedef struct packed {
        logic [1:0]              lead;
        logic [DIGITS-1:0][3:0]  dec;
    } chain_t;

    chain_t cur_q, nxt_d;
    logic   carry;

    always_comb begin
        nxt_d = cur_q;
        carry = inc;
        for (int i = 0; i < DIGITS; i++) begin
            if (carry) begin
                if (cur_q.dec[i] == 4'd9) begin
                    nxt_d.dec[i] = 4'd0;
                end else begin
                    nxt_d.dec[i] = cur_q.dec[i] + 4'd1;
                    carry = 1'b0;
                end
            end
        end
        if (carry) nxt_d.lead = cur_q.lead + 2'd1;
        if (clr)   nxt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign value = cur_q;

    for (genvar g = 0; g < DIGITS; g++) begin : g_chk
        p_decade_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cur_q.dec[g] <= 4'd9)
            else $error("decade %0d out of BCD range", g);
    end

endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
    import dslope_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES  = 2000,
    parameter int unsigned RUNUP_CYCLES   = 20000,
    parameter int unsigned TIMEOUT_CYCLES = 40000,
    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + SETTLE_CYCLES + RUNUP_CYCLES + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   cmp_zero,
    output phase_e phase,
    output logic   chain_clr,
    output logic   chain_inc,
    output logic   xfer,
    output logic   force_ovr
);

    localparam logic [TW-1:0] SET_LAST = TW'(SETTLE_CYCLES - 1);
    localparam logic [TW-1:0] RU_LAST  = TW'(RUNUP_CYCLES - 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        phase_e          phase;
        logic [TW-1:0]   tick;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        chain_clr = 1'b0;
        chain_inc = 1'b0;
        xfer      = 1'b0;
        force_ovr = 1'b0;
        case (cur_q.phase)
            PH_IDLE: begin
                if (start) begin
                    nxt_d.phase = PH_SETTLE;
                    nxt_d.tick  = '0;
                    chain_clr   = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (cur_q.tick == SET_LAST) begin
                    nxt_d.phase = PH_RUNUP;
                    nxt_d.tick  = '0;
                end else begin
                    nxt_d.tick = cur_q.tick + 1'b1;
                end
            end
            PH_RUNUP: begin
                chain_inc = 1'b1;
                if (cur_q.tick == RU_LAST) begin
                    nxt_d.phase = PH_RUNDOWN;
                    nxt_d.tick  = '0;
                    chain_clr   = 1'b1;
                end else begin
                    nxt_d.tick = cur_q.tick + 1'b1;
                end
            end
            PH_RUNDOWN: begin
                if (cmp_zero) begin
                    xfer        = 1'b1;
                    nxt_d.phase = PH_IDLE;
                    nxt_d.tick  = '0;
                end else if (cur_q.tick == TMO_LAST) begin
                    xfer        = 1'b1;
                    force_ovr   = 1'b1;
                    nxt_d.phase = PH_IDLE;
                    nxt_d.tick  = '0;
                end else begin
                    chain_inc  = 1'b1;
                    nxt_d.tick = cur_q.tick + 1'b1;
                end
            end
            default: nxt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign phase = cur_q.phase;

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_RUNUP && cur_q.tick != RU_LAST) |=> (cur_q.phase == PH_RUNUP))
        else $error("charge phase disturbed");

    p_settle_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_SETTLE) |=> (cur_q.phase == PH_SETTLE || cur_q.phase == PH_RUNUP))
        else $error("settle left to wrong phase");

    p_tick_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_RUNDOWN) |-> (cur_q.tick <= TMO_LAST))
        else $error("discharge exceeded timeout");

    p_idle_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_IDLE && !$past(cur_q.phase == PH_IDLE)) |-> $past(cur_q.phase == PH_RUNDOWN))
        else $error("idle entered from a phase other than discharge");

endmodule

// File: rtl/dslope_result_latch.sv
module dslope_result_latch #(
    parameter int unsigned DIGITS = 4,
    localparam int unsigned W = 4 * DIGITS + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer,
    input  logic         force_ovr,
    input  logic [W-1:0] value,
    output logic [W-1:0] result,
    output logic         overrange,
    output logic         done
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         ovr;
        logic         done;
    } lat_t;

    lat_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = xfer;
        if (xfer) begin
            nxt_d.res = value;
            nxt_d.ovr = force_ovr | value[W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign result    = cur_q.res;
    assign overrange = cur_q.ovr;
    assign done      = cur_q.done;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(result) && $stable(overrange)))
        else $error("result changed without transfer");

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 2000,
    parameter int unsigned DIGITS        = 4,
    localparam int unsigned RUNUP_CYCLES   = 2 * pow10(DIGITS),
    localparam int unsigned TIMEOUT_CYCLES = 2 * RUNUP_CYCLES,
    localparam int unsigned W              = 4 * DIGITS + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_zero,
    output logic         sw_signal,
    output logic         sw_zero_in,
    output logic         sw_autozero,
    output logic         sw_int_input,
    output logic         sw_int_ref,
    output logic         sw_int_reset,
    output logic         gate,
    output logic [W-1:0] result,
    output logic         overrange,
    output logic         done
);

    phase_e       phase;
    logic         chain_clr, chain_inc, xfer, force_ovr;
    logic [W-1:0] count;

    dslope_sequencer #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .RUNUP_CYCLES  (RUNUP_CYCLES),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_zero (cmp_zero),
        .phase    (phase),
        .chain_clr(chain_clr),
        .chain_inc(chain_inc),
        .xfer     (xfer),
        .force_ovr(force_ovr)
    );

    dslope_bcd_chain #(.DIGITS(DIGITS)) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (chain_clr),
        .inc  (chain_inc),
        .value(count)
    );

    dslope_result_latch #(.DIGITS(DIGITS)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer),
        .force_ovr(force_ovr),
        .value    (count),
        .result   (result),
        .overrange(overrange),
        .done     (done)
    );

    always_comb begin
        sw_signal    = 1'b0;
        sw_zero_in   = 1'b0;
        sw_autozero  = 1'b0;
        sw_int_input = 1'b0;
        sw_int_ref   = 1'b0;
        sw_int_reset = 1'b0;
        gate         = 1'b0;
        case (phase)
            PH_IDLE: begin
                sw_zero_in   = 1'b1;
                sw_autozero  = 1'b1;
                sw_int_reset = 1'b1;
            end
            PH_SETTLE: sw_signal = 1'b1;
            PH_RUNUP: begin
                sw_signal    = 1'b1;
                sw_int_input = 1'b1;
                gate         = 1'b1;
            end
            PH_RUNDOWN: begin
                sw_zero_in  = 1'b1;
                sw_autozero = 1'b1;
                sw_int_ref  = 1'b1;
            end
            default: ;
        endcase
    end

    p_ref_after_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> sw_int_ref)
        else $error("discharge did not follow charge");

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sw_int_reset && !sw_int_ref))
        else $error("done outside idle");

    p_int_paths_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_int_input, sw_int_ref, sw_int_reset}))
        else $error("integrator paths overlap");

endmodule

// File: tb/tb_dslope_seq.sv
module tb_dslope_seq;

    localparam int D   = 2;
    localparam int SET = 10;
    localparam int RU  = 200;
    localparam int TMO = 400;
    localparam int W   = 4 * D + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_zero = 1'b0;
    logic sw_signal, sw_zero_in, sw_autozero, sw_int_input, sw_int_ref, sw_int_reset, gate;
    logic [W-1:0] result;
    logic overrange, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [W-1:0] prev_res = '0;
    logic prev_ovr = 1'b0;

    always #4 clk = ~clk;

    dslope_seq #(.SETTLE_CYCLES(SET), .DIGITS(D)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_zero(cmp_zero),
        .sw_signal(sw_signal), .sw_zero_in(sw_zero_in), .sw_autozero(sw_autozero),
        .sw_int_input(sw_int_input), .sw_int_ref(sw_int_ref), .sw_int_reset(sw_int_reset),
        .gate(gate), .result(result), .overrange(overrange), .done(done)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int x;
        r = '0;
        x = v;
        for (int i = 0; i < D; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        r[4*D +: 2] = 2'(x);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sw_vec();
        return {25'd0, sw_signal, sw_zero_in, sw_autozero, sw_int_input, sw_int_ref, sw_int_reset, gate};
    endfunction

    localparam int PAT_IDLE   = 7'b0110010;
    localparam int PAT_SETTLE = 7'b1000000;
    localparam int PAT_RUNUP  = 7'b1001001;
    localparam int PAT_RDOWN  = 7'b0110100;

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // n < 0: comparator never trips (timeout)
    task automatic measure(input int n, input bit cmp_early, input bit poke);
        int cnt;
        int seen;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(sw_vec() == PAT_SETTLE, "R3 settle pattern", sw_vec(), PAT_SETTLE);
        check(result == prev_res && overrange == prev_ovr, "R9 hold during settle", int'(result), int'(prev_res));
        if (cmp_early) cmp_zero = 1'b1;
        cnt = 1;
        for (int j = 0; j < SET + 5; j++) begin
            @(negedge clk);
            if (gate) break;
            cnt++;
        end
        check(cnt == SET, "R2 settle length", cnt, SET);
        check(sw_vec() == PAT_RUNUP, "R4 charge pattern", sw_vec(), PAT_RUNUP);
        cnt = 1;
        for (int j = 0; j < RU + 5; j++) begin
            if (poke && cnt == 50) start = 1'b1;
            if (cnt == 51) start = 1'b0;
            @(negedge clk);
            if (!gate) break;
            cnt++;
        end
        start = 1'b0;
        check(cnt == RU, "R4 charge length (R10 start ignored)", cnt, RU);
        cmp_zero = 1'b0;
        check(sw_vec() == PAT_RDOWN, "R5 discharge pattern", sw_vec(), PAT_RDOWN);
        if (n < 0) begin
            seen = -1;
            for (int j = 1; j <= TMO + 3; j++) begin
                @(negedge clk);
                if (done) begin seen = j; break; end
            end
            check(seen == TMO, "R8 timeout edge", seen, TMO);
            check(result == to_bcd(TMO - 1), "R8 timeout result", int'(result), int'(to_bcd(TMO - 1)));
            check(overrange == 1'b1, "R8 timeout overrange", int'(overrange), 1);
            prev_res = to_bcd(TMO - 1);
            prev_ovr = 1'b1;
        end else begin
            seen = 0;
            for (int j = 0; j < n; j++) begin
                @(negedge clk);
                if (done) seen = 1;
            end
            check(seen == 0, "R11 no early done", seen, 0);
            cmp_zero = 1'b1;
            @(negedge clk);
            cmp_zero = 1'b0;
            check(done == 1'b1, "R6 done strobe", int'(done), 1);
            check(result == to_bcd(n), "R6 result", int'(result), int'(to_bcd(n)));
            check(overrange == (n >= RU), "R7 overrange", int'(overrange), int'(n >= RU));
            prev_res = to_bcd(n);
            prev_ovr = (n >= RU);
        end
        check(sw_vec() == PAT_IDLE, "R1 idle after transfer", sw_vec(), PAT_IDLE);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(sw_vec() == PAT_IDLE, "R1 reset pattern", sw_vec(), PAT_IDLE);
        check(result == '0 && overrange == 1'b0 && done == 1'b0, "R1 reset outputs", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // comparator in idle has no effect
        cmp_zero = 1'b1;
        repeat (5) @(negedge clk);
        check(done == 1'b0 && sw_vec() == PAT_IDLE, "R11 cmp ignored in idle", int'(done), 0);
        cmp_zero = 1'b0;
        @(negedge clk);
        measure(0, 1'b0, 1'b0);
        measure(1, 1'b1, 1'b0);
        measure(RU - 1, 1'b0, 1'b1);
        measure(RU, 1'b0, 1'b0);
        measure(TMO - 1, 1'b0, 1'b0);
        measure(-1, 1'b0, 1'b0);
        cmp_zero = 1'b1;
        repeat (4) @(negedge clk);
        cmp_zero = 1'b0;
        check(result == prev_res && overrange == prev_ovr && !done, "R9 hold in idle", int'(result), int'(prev_res));
        for (int k = 0; k < 30; k++) begin
            int n;
            n = int'($urandom % TMO);
            measure(n, 1'($urandom % 2), 1'($urandom % 2));
            repeat (int'($urandom % 4)) @(negedge clk);
        end
        finish_up();
    end

endmodule